// File: doc/BRIEF.md
# Fixed-Priority Eight-Line Interrupt Controller

This block gathers eight interrupt request lines from peripherals and presents a single interrupt signal to a processor. Each line is watched for a rising edge, and the edge is latched as a pending request. A per-line mask can stop a pending request from being forwarded. The line with the lowest index always wins. The block forwards a request only when that request outranks every line the processor is already servicing. Lower-priority work therefore waits, while a more urgent line can nest on top of it.

When the processor acknowledges, the block moves the winning request into its in-service set. In the following cycle it returns an 8-bit type number, equal to the line index plus 08H. Software finishes a handler by writing an end-of-interrupt code to the command register. That write retires the most urgent in-service line, so lower-priority pending requests may be forwarded again.

Software reaches the block through a small register port with a one-bit select. Select 0 is the command register. Select 1 is the mask register.

Top module: `prio_irq_hub`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), irq_out and vec_valid are 0, the mask reads 8'hFF (all lines blocked), and the in-service set reads 8'h00.
- R2: A write with reg_sel=1 loads reg_wdata into the mask, which is readable with reg_sel=1 on reg_rdata. Bit n set to 1 blocks line n, and 0 enables it. Writing 8'hFE leaves only line 0 able to raise irq_out.
- R3: A request is latched on a 0-to-1 transition of its line. A one-cycle pulse stays pending after the line falls. A line held high is not latched a second time.
- R4: Line 0 has the highest priority and line 7 the lowest. irq_out is 1 exactly when some unmasked pending line has a lower index than every in-service line, or when such a line exists and nothing is in service. irq_out follows the first clock edge that sees the request edge.
- R5: An edge with cpu_ack=1 and irq_out=1 clears the winning line from pending and sets it in the in-service set. After that edge, vec_valid is 1 for one cycle, with vec_out = 8'h08 + line index (line 0 gives 8'h08, line 7 gives 8'h0F).
- R6: An edge with cpu_ack=1 and irq_out=0 changes nothing: vec_valid stays 0 and the in-service set is unchanged.
- R7: A write with reg_sel=0 and reg_wdata=8'h20 clears the lowest-index in-service bit. A write of any other value with reg_sel=0 has no effect. The in-service set is readable with reg_sel=0 on reg_rdata (bit n = line n).
- R8: A masked pending request remains pending and raises irq_out once its mask bit is cleared.
- R9: While a line is in service, a pending line of higher priority raises irq_out and can be acknowledged. That nests a second in-service bit, and the first end-of-interrupt retires the nested one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 8 | Request lines, bit n is line n |
| cpu_ack | input | 1 | Processor acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 mask |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | In-service set (sel 0) or mask (sel 1) |
| irq_out | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | Type number valid, one cycle after acknowledge |
| vec_out | output | 8 | Interrupt type number |

## Verification
The hardest state to reach from the ports is a nested in-service set. In that state, a lower-priority line must stay blocked, and end-of-interrupt must retire the nested line and not the first one. The stimulus first acknowledges line 3 and then raises line 5, which must stay silent. It then pulses line 1 for a single cycle, acknowledges it, and walks two end-of-interrupt writes to watch line 5 get through only at the end. The scoreboard queues the expected type number for every acknowledge and matches each one when vec_valid appears.

// File: rtl/irqc_pkg.sv
// Shared definitions for the eight-line interrupt controller.
// Assumes a single register-select bit and byte-wide register data.
package irqc_pkg;
    localparam int unsigned LINES_DEF = 8;
    localparam int unsigned DATA_W    = 8;

    typedef enum logic {
        SEL_CMD  = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irqc_req_latch.sv
// Rising-edge request capture, one slice per line.
// Assumes request lines are already synchronous to clk.
// A clear and a fresh edge on the same line in the same cycle leave the line pending.
module irqc_req_latch #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend_out
);
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        // Remember the last level and hold the pending flag of this line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= req_in[g];
                pend_q[g] <= (pend_q[g] & ~clr_vec[g]) | (req_in[g] & ~prev_q[g]);
            end
        end
    end

    assign pend_out = pend_q;
endmodule

// File: rtl/irqc_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
// Purely combinational; gives the index and a one-hot copy of the winner.
module irqc_prio_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_in,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    // Scan from the top so that the lowest set index is written last.
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_in[i]) begin
                any    = 1'b1;
                idx    = IW'(i);
                onehot = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/irqc_regs.sv
// Register port: mask register and decode of the end-of-interrupt command.
// Assumes single-cycle write strobes.
module irqc_regs #(
    parameter int unsigned N         = 8,
    parameter logic [N-1:0] MASK_RST = '1,
    parameter logic [N-1:0] EOI_CODE = N'(8'h20)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         sel,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask_q,
    output logic         eoi_pulse
);
    import irqc_pkg::*;

    // Load the mask register on a write to the mask select.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= MASK_RST;
        else if (wr && sel == SEL_MASK) mask_q <= wdata;
    end

    // Recognise the end-of-interrupt code on the command select.
    always_comb eoi_pulse = wr && (sel == SEL_CMD) && (wdata == EOI_CODE);
endmodule

// File: rtl/prio_irq_hub.sv
// Eight-line fixed-priority interrupt controller (top).
// Captures edges, masks, forwards the best request above the in-service level,
// returns base+index one cycle after acknowledge, and retires on end-of-interrupt.
// Assumes the processor acknowledges only while irq_out is high.
module prio_irq_hub #(
    parameter int unsigned  N        = irqc_pkg::LINES_DEF,
    parameter int unsigned  VEC_W    = irqc_pkg::DATA_W,
    parameter logic [7:0]   VEC_BASE = 8'h08,
    parameter logic [7:0]   EOI_CODE = 8'h20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_req,
    input  logic         cpu_ack,
    input  logic         reg_wr,
    input  logic         reg_sel,
    input  logic [N-1:0] reg_wdata,
    output logic [N-1:0] reg_rdata,
    output logic         irq_out,
    output logic         vec_valid,
    output logic [VEC_W-1:0] vec_out
);
    localparam int unsigned IW = $clog2(N);

    logic [N-1:0]  pend;
    logic [N-1:0]  mask_q;
    logic [N-1:0]  insvc_q;
    logic [N-1:0]  eligible;
    logic          eoi_pulse;
    logic          win_any, isv_any;
    logic [IW-1:0] win_idx, isv_idx;
    logic [N-1:0]  win_oh, isv_oh;
    logic          take;

    irqc_regs #(.N(N), .MASK_RST('1), .EOI_CODE(N'(EOI_CODE))) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .mask_q(mask_q), .eoi_pulse(eoi_pulse)
    );

    irqc_req_latch #(.N(N)) u_latch (
        .clk(clk), .rst_n(rst_n), .req_in(irq_req),
        .clr_vec(take ? win_oh : '0), .pend_out(pend)
    );

    always_comb eligible = pend & ~mask_q;

    irqc_prio_pick #(.N(N), .IW(IW)) u_pick_req (
        .vec_in(eligible), .any(win_any), .idx(win_idx), .onehot(win_oh)
    );

    irqc_prio_pick #(.N(N), .IW(IW)) u_pick_isv (
        .vec_in(insvc_q), .any(isv_any), .idx(isv_idx), .onehot(isv_oh)
    );

    // Forward only when the best request outranks every in-service line.
    always_comb irq_out = win_any && (!isv_any || (win_idx < isv_idx));

    always_comb take = cpu_ack && irq_out;

    // Retire the top in-service line on EOI, then add the acknowledged one.
    always_ff @(posedge clk) begin
        if (!rst_n) insvc_q <= '0;
        else insvc_q <= (insvc_q & ~(eoi_pulse ? isv_oh : '0)) | (take ? win_oh : '0);
    end

    // Register the type number for the cycle after the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= take;
            if (take) vec_out <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        end
    end

    // Read mux: in-service set on the command select, mask on the mask select.
    always_comb reg_rdata = reg_sel ? mask_q : insvc_q;
endmodule

// File: rtl/irqc_chk.sv
// Property checker for prio_irq_hub, attached by bind below.
module irqc_chk #(
    parameter int unsigned N        = 8,
    parameter int unsigned VEC_W    = 8,
    parameter logic [7:0]  VEC_BASE = 8'h08,
    parameter logic [7:0]  EOI_CODE = 8'h20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ack,
    input logic             irq_out,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [N-1:0]     reg_wdata,
    input logic [N-1:0]     mask_q,
    input logic [N-1:0]     insvc_q
);
    logic eoi_w;
    always_comb eoi_w = reg_wr && !reg_sel && (reg_wdata == N'(EOI_CODE));

    // R2: a mask write is visible in the mask on the next cycle
    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> (mask_q == $past(reg_wdata)));

    // R5: a taken acknowledge adds exactly one in-service line
    a_r5_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq_out && !eoi_w) |=> ($countones(insvc_q) == $countones($past(insvc_q)) + 1));

    // R5: a delivered type number lies in the base..base+N-1 window
    a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec_out >= VEC_W'(VEC_BASE)) && (vec_out < VEC_W'(VEC_BASE) + VEC_W'(N))));

    // R6: an acknowledge without a request gives no type number
    a_r6_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !irq_out) |=> !vec_valid);

    // R7: end-of-interrupt removes exactly one in-service line
    a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_w && (insvc_q != '0) && !(cpu_ack && irq_out))
        |=> ($countones(insvc_q) == $countones($past(insvc_q)) - 1));

    // R7: without acknowledge or end-of-interrupt the in-service set holds
    a_r7_isv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ack && !eoi_w) |=> $stable(insvc_q));
endmodule

bind prio_irq_hub irqc_chk #(.N(N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .EOI_CODE(EOI_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .irq_out(irq_out),
    .vec_valid(vec_valid), .vec_out(vec_out), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mask_q(mask_q), .insvc_q(insvc_q)
);

// File: tb/test_prio_irq_hub.sv
module test_prio_irq_hub;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       cpu_ack = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_out;
    logic       vec_valid;
    logic [7:0] vec_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    prio_irq_hub i_prio_irq_hub (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cpu_ack(cpu_ack),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected type numbers as the design delivers them.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R5 unexpected vector actual=%h expected=none", vec_out);
            end else begin
                check(tag_q.pop_front(), vec_out, exp_q.pop_front());
            end
        end
    end

    // All tasks start and end at a falling edge.
    task automatic reg_write(input logic s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_reg(input logic s, output logic [7:0] v);
        reg_sel = s; #1; v = reg_rdata; reg_sel = 1'b0;
    endtask

    task automatic set_req(input logic [7:0] v);
        irq_req = v;
        @(negedge clk);
    endtask

    task automatic ack_expect(input logic [7:0] vec, input string tag);
        exp_q.push_back(vec); tag_q.push_back(tag);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq_out", {7'd0, irq_out}, 8'h00);
        check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        read_reg(1'b1, rv); check("R1 mask", rv, 8'hFF);
        read_reg(1'b0, rv); check("R1 in-service", rv, 8'h00);

        // R2 mask write and readback, only line 0 enabled
        reg_write(1'b1, 8'hFE);
        read_reg(1'b1, rv); check("R2 mask readback", rv, 8'hFE);
        set_req(8'h08);
        check("R2 masked line 3 silent", {7'd0, irq_out}, 8'h00);
        set_req(8'h09);
        check("R4 line 0 raises irq", {7'd0, irq_out}, 8'h01);
        ack_expect(8'h08, "R5 vector line 0");
        read_reg(1'b0, rv); check("R5 in-service line 0", rv, 8'h01);
        check("R5 irq drops after ack", {7'd0, irq_out}, 8'h00);

        // R7 non-EOI command ignored, then EOI
        reg_write(1'b0, 8'h55);
        read_reg(1'b0, rv); check("R7 other code ignored", rv, 8'h01);
        reg_write(1'b0, 8'h20);
        read_reg(1'b0, rv); check("R7 EOI clears", rv, 8'h00);

        // R8 unmask releases latched line 3
        reg_write(1'b1, 8'h00);
        check("R8 unmask forwards", {7'd0, irq_out}, 8'h01);
        ack_expect(8'h0B, "R8 vector line 3");
        read_reg(1'b0, rv); check("R8 in-service line 3", rv, 8'h08);

        // R4 lower priority blocked while line 3 in service
        set_req(8'h29);
        check("R4 line 5 blocked", {7'd0, irq_out}, 8'h00);
        // R3/R9 one-cycle pulse on line 1 nests
        set_req(8'h2B);
        set_req(8'h29);
        check("R3 pulse remembered", {7'd0, irq_out}, 8'h01);
        ack_expect(8'h09, "R9 vector line 1");
        read_reg(1'b0, rv); check("R9 nested in-service", rv, 8'h0A);
        reg_write(1'b0, 8'h20);
        read_reg(1'b0, rv); check("R9 EOI retires nested", rv, 8'h08);
        check("R4 line 5 still blocked", {7'd0, irq_out}, 8'h00);
        reg_write(1'b0, 8'h20);
        check("R4 line 5 after EOI", {7'd0, irq_out}, 8'h01);
        ack_expect(8'h0D, "R5 vector line 5");
        reg_write(1'b0, 8'h20);
        read_reg(1'b0, rv); check("R7 all retired", rv, 8'h00);

        // R3 levels still high are not latched again
        @(negedge clk);
        check("R3 held level no relatch", {7'd0, irq_out}, 8'h00);

        // R6 acknowledge with nothing pending
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        check("R6 no vector", {7'd0, vec_valid}, 8'h00);
        read_reg(1'b0, rv); check("R6 in-service unchanged", rv, 8'h00);

        // R4 simultaneous edges served lowest index first
        set_req(8'h00);
        set_req(8'hC4);
        ack_expect(8'h0A, "R4 first of three");
        reg_write(1'b0, 8'h20);
        ack_expect(8'h0E, "R4 second of three");
        reg_write(1'b0, 8'h20);
        ack_expect(8'h0F, "R4 third of three");
        reg_write(1'b0, 8'h20);
        check("R4 queue drained", {7'd0, irq_out}, 8'h00);
        check("R5 scoreboard empty", 8'(exp_q.size()), 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule